// File: doc/BRIEF.md
# Neutral-Point Balance Duty Adjuster

This block sits between the nearest-vector duty calculation and the PWM timers of a three-level inverter whose DC link has a quasi-impedance boost network. For the active region it takes four duties in Q1.15: a first redundant small vector, two middle vectors and a last redundant small vector. It also takes the two sampled DC-link capacitor voltages, a proportional gain, the modulation index and the shoot-through duty. From the capacitor imbalance it forms a distribution factor. The factor is saturated to Q1.15 and then limited to a band that the modulation index and the shoot-through duty set.

Both redundant small-vector duties give up the shoot-through duty, which becomes boost time. They are also shifted in opposite directions by the factor, which steers charge toward the lower capacitor. The middle duties pass through untouched. Every duty is then scaled by the period length into an integer dwell count, and one shoot-through dwell of half a period's worth of the shoot-through duty is produced. With zero shoot-through duty the block reduces to plain neutral-point balancing. With balancing disabled it only injects shoot-through time.

Top module: `np_balance_adjust`

## Requirements
- R1: The raw factor is floor(gain × (vc_hi − vc_lo) / 2^GAIN_FRAC), computed without overflow and then saturated to the signed Q1.15 range [−32768, 32767].
- R2: The factor is limited to the open interval ±(1 − m − df). In Q1.15 its magnitude never exceeds L = 32768 − mod_idx − st_duty − 1. When L < 0 the factor is 0.
- R3: When bal_en is low at the input strobe, the factor (eta output) is 0 whatever the voltages and the gain.
- R4: The first small-vector duty is revised to duty_a − st_duty − eta, and the last to duty_d − st_duty + eta.
- R5: The middle duties duty_b and duty_c are used unchanged.
- R6: Each segment dwell equals floor(r × period / 32768), where r is the revised duty clipped to the range [0, 32768]. No dwell exceeds period.
- R7: dwell_st equals floor(st_duty × period / 65536), which is half a period's worth of the shoot-through duty.
- R8: A revised duty below zero gives a dwell of 0 and raises neg_sat. A revised duty above 32768 is clipped to 32768 and does not raise neg_sat.
- R9: out_valid pulses exactly two clock cycles after in_valid. All result outputs keep their values between strobes.
- R10: After reset, out_valid, eta, neg_sat and every dwell are 0.
- R11: With st_duty = 0, dwell_st is 0 and the small-vector revisions reduce to ±eta alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: the inputs hold a new set for this period |
| bal_en | input | 1 | Neutral-point balancing enable |
| duty_a | input | DUTY_W | First redundant small-vector duty, Q1.15 |
| duty_b | input | DUTY_W | First middle-vector duty, Q1.15 |
| duty_c | input | DUTY_W | Second middle-vector duty, Q1.15 |
| duty_d | input | DUTY_W | Last redundant small-vector duty, Q1.15 |
| vc_hi | input | VOLT_W | Upper capacitor voltage sample, signed |
| vc_lo | input | VOLT_W | Lower capacitor voltage sample, signed |
| gain | input | GAIN_W | Proportional gain, signed, GAIN_FRAC fractional bits |
| mod_idx | input | DUTY_W | Modulation index, Q1.15 |
| st_duty | input | DUTY_W | Shoot-through duty, Q1.15 |
| period | input | PER_W | Period length in timer counts |
| out_valid | output | 1 | Result strobe |
| eta | output | DUTY_W | Clamped distribution factor, Q1.15 |
| dwell_a | output | PER_W | First small-vector dwell count |
| dwell_b | output | PER_W | First middle-vector dwell count |
| dwell_c | output | PER_W | Second middle-vector dwell count |
| dwell_d | output | PER_W | Last small-vector dwell count |
| dwell_st | output | PER_W | Shoot-through dwell count (half period share) |
| neg_sat | output | 1 | A revised duty was negative and was forced to zero |

## Verification
The results appear after two registered stages. The factor is captured on the first edge after the strobe, and the revised duties, dwell counts and flag on the second, together with out_valid. The bench therefore drives each stimulus on a falling edge and checks that out_valid is still low one falling edge later. It compares every result on the falling edge that follows the second rising edge. For back-to-back strobes it checks the first result before the second strobe's result replaces it, and it confirms that results hold steady while the inputs wander with no strobe.

// File: rtl/np_bal_pkg.sv
package np_bal_pkg;

   localparam int DEF_DUTY_W    = 16;
   localparam int DEF_VOLT_W    = 16;
   localparam int DEF_GAIN_W    = 16;
   localparam int DEF_GAIN_FRAC = 12;
   localparam int DEF_PER_W     = 16;

   typedef enum logic [1:0] {
      SAT_NONE = 2'd0,
      SAT_LOW  = 2'd1,
      SAT_HIGH = 2'd2
   } sat_e;

endpackage

// File: rtl/np_bal_factor.sv
module np_bal_factor #(
   parameter int DW = 16,
   parameter int VW = 16,
   parameter int GW = 16,
   parameter int GF = 12
) (
   input  logic                 bal_en,
   input  logic signed [VW-1:0] vc_hi,
   input  logic signed [VW-1:0] vc_lo,
   input  logic signed [GW-1:0] gain,
   input  logic signed [DW-1:0] mod_idx,
   input  logic signed [DW-1:0] st_duty,
   output logic signed [DW-1:0] eta
);
   localparam int PRW  = VW + 1 + GW;
   localparam int XW   = DW + 2;
   localparam int MAXI = (2 ** (DW - 1)) - 1;
   localparam int ONEI = 2 ** (DW - 1);
   localparam logic signed [PRW-1:0] SAT_HI = PRW'(MAXI);
   localparam logic signed [PRW-1:0] SAT_LO = PRW'(-MAXI - 1);

   if (GF >= PRW - 1) begin : g_bad_frac
      $error("np_bal_factor: GF too large for product width");
   end
   if (DW < 4) begin : g_bad_dw
      $error("np_bal_factor: DW must be at least 4");
   end

   logic signed [VW:0]     diff;
   logic signed [PRW-1:0]  prod;
   logic signed [PRW-1:0]  shf;
   logic signed [DW-1:0]   sat_v;
   logic signed [XW-1:0]   lim;
   logic signed [XW-1:0]   nlim;
   logic signed [XW-1:0]   eta_x;

   always_comb begin
      diff = {vc_hi[VW-1], vc_hi} - {vc_lo[VW-1], vc_lo};
      prod = PRW'(diff) * PRW'(gain);
      shf  = prod >>> GF;
      if (shf > SAT_HI)      sat_v = SAT_HI[DW-1:0];
      else if (shf < SAT_LO) sat_v = SAT_LO[DW-1:0];
      else                   sat_v = shf[DW-1:0];
   end

   always_comb begin
      lim   = XW'(ONEI) - XW'(mod_idx) - XW'(st_duty) - XW'(1);
      nlim  = -lim;
      eta_x = XW'(sat_v);
      if (!bal_en || lim < 0) eta = '0;
      else if (eta_x > lim)   eta = lim[DW-1:0];
      else if (eta_x < nlim)  eta = nlim[DW-1:0];
      else                    eta = sat_v;
   end

endmodule

// File: rtl/np_bal_dwell.sv
module np_bal_dwell #(
   parameter int DW   = 16,
   parameter int PW   = 16,
   parameter bit HALF = 1'b0
) (
   input  logic signed [DW+1:0] rev,
   input  logic [PW-1:0]        period,
   output logic [PW-1:0]        dwell,
   output np_bal_pkg::sat_e     sat
);
   import np_bal_pkg::*;

   localparam int XW   = DW + 2;
   localparam int ONEI = 2 ** (DW - 1);
   localparam logic signed [XW-1:0] ONE_X = XW'(ONEI);
   localparam logic [DW-1:0]        ONE_U = DW'(ONEI);

   logic [DW-1:0]    mag;
   logic [DW+PW-1:0] prod;

   always_comb begin
      if (rev < 0) begin
         mag = '0;
         sat = SAT_LOW;
      end else if (rev > ONE_X) begin
         mag = ONE_U;
         sat = SAT_HIGH;
      end else begin
         mag = rev[DW-1:0];
         sat = SAT_NONE;
      end
      prod = (DW+PW)'(mag) * (DW+PW)'(period);
   end

   if (HALF) begin : g_half
      assign dwell = PW'(prod >> DW);
   end else begin : g_full
      assign dwell = PW'(prod >> (DW - 1));
   end

endmodule

// File: rtl/np_balance_adjust.sv
module np_balance_adjust #(
   parameter int DUTY_W    = np_bal_pkg::DEF_DUTY_W,
   parameter int VOLT_W    = np_bal_pkg::DEF_VOLT_W,
   parameter int GAIN_W    = np_bal_pkg::DEF_GAIN_W,
   parameter int GAIN_FRAC = np_bal_pkg::DEF_GAIN_FRAC,
   parameter int PER_W     = np_bal_pkg::DEF_PER_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     bal_en,
   input  logic signed [DUTY_W-1:0] duty_a,
   input  logic signed [DUTY_W-1:0] duty_b,
   input  logic signed [DUTY_W-1:0] duty_c,
   input  logic signed [DUTY_W-1:0] duty_d,
   input  logic signed [VOLT_W-1:0] vc_hi,
   input  logic signed [VOLT_W-1:0] vc_lo,
   input  logic signed [GAIN_W-1:0] gain,
   input  logic signed [DUTY_W-1:0] mod_idx,
   input  logic signed [DUTY_W-1:0] st_duty,
   input  logic [PER_W-1:0]         period,
   output logic                     out_valid,
   output logic signed [DUTY_W-1:0] eta,
   output logic [PER_W-1:0]         dwell_a,
   output logic [PER_W-1:0]         dwell_b,
   output logic [PER_W-1:0]         dwell_c,
   output logic [PER_W-1:0]         dwell_d,
   output logic [PER_W-1:0]         dwell_st,
   output logic                     neg_sat
);
   import np_bal_pkg::*;

   localparam int NSEG = 4;
   localparam int XW   = DUTY_W + 2;
   localparam int ONEI = 2 ** (DUTY_W - 1);

   if (PER_W < 2) begin : g_bad_per
      $error("np_balance_adjust: PER_W must be at least 2");
   end
   if (VOLT_W < 2 || GAIN_W < 2) begin : g_bad_in
      $error("np_balance_adjust: VOLT_W and GAIN_W must be at least 2");
   end

   // ---------------- stage 1: distribution factor ----------------
   logic signed [DUTY_W-1:0] eta_n;

   np_bal_factor #(
      .DW(DUTY_W), .VW(VOLT_W), .GW(GAIN_W), .GF(GAIN_FRAC)
   ) u_factor (
      .bal_en (bal_en),
      .vc_hi  (vc_hi),
      .vc_lo  (vc_lo),
      .gain   (gain),
      .mod_idx(mod_idx),
      .st_duty(st_duty),
      .eta    (eta_n)
   );

   logic                     s1_vld;
   logic signed [DUTY_W-1:0] s1_eta;
   logic signed [DUTY_W-1:0] s1_df;
   logic signed [DUTY_W-1:0] s1_m;
   logic [PER_W-1:0]         s1_per;
   logic signed [DUTY_W-1:0] s1_d [NSEG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_eta <= '0;
         s1_df  <= '0;
         s1_m   <= '0;
         s1_per <= '0;
         for (int i = 0; i < NSEG; i++) s1_d[i] <= '0;
      end else begin
         s1_vld <= in_valid;
         if (in_valid) begin
            s1_eta  <= eta_n;
            s1_df   <= st_duty;
            s1_m    <= mod_idx;
            s1_per  <= period;
            s1_d[0] <= duty_a;
            s1_d[1] <= duty_b;
            s1_d[2] <= duty_c;
            s1_d[3] <= duty_d;
         end
      end
   end

   // ---------------- stage 2: revision and dwell scaling ----------------
   logic signed [XW-1:0] rev [NSEG];
   logic [PER_W-1:0]     dw_n [NSEG];
   sat_e                 sat [NSEG];
   logic [PER_W-1:0]     st_n;
   sat_e                 st_sat;
   logic                 neg_n;

   always_comb begin
      rev[0] = XW'(s1_d[0]) - XW'(s1_df) - XW'(s1_eta);
      rev[1] = XW'(s1_d[1]);
      rev[2] = XW'(s1_d[2]);
      rev[3] = XW'(s1_d[3]) - XW'(s1_df) + XW'(s1_eta);
   end

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      np_bal_dwell #(.DW(DUTY_W), .PW(PER_W), .HALF(1'b0)) u_dwell (
         .rev   (rev[g]),
         .period(s1_per),
         .dwell (dw_n[g]),
         .sat   (sat[g])
      );
   end

   np_bal_dwell #(.DW(DUTY_W), .PW(PER_W), .HALF(1'b1)) u_st_dwell (
      .rev   (XW'(s1_df)),
      .period(s1_per),
      .dwell (st_n),
      .sat   (st_sat)
   );

   always_comb begin
      neg_n = 1'b0;
      for (int i = 0; i < NSEG; i++) begin
         if (sat[i] == SAT_LOW) neg_n = 1'b1;
      end
   end

   logic [PER_W-1:0] dw_q [NSEG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         eta       <= '0;
         dwell_st  <= '0;
         neg_sat   <= 1'b0;
         for (int i = 0; i < NSEG; i++) dw_q[i] <= '0;
      end else begin
         out_valid <= s1_vld;
         if (s1_vld) begin
            eta      <= s1_eta;
            dwell_st <= st_n;
            neg_sat  <= neg_n;
            for (int i = 0; i < NSEG; i++) dw_q[i] <= dw_n[i];
         end
      end
   end

   assign dwell_a = dw_q[0];
   assign dwell_b = dw_q[1];
   assign dwell_c = dw_q[2];
   assign dwell_d = dw_q[3];

   // ---------------- assertions ----------------
   logic signed [XW-1:0] chk_band;
   logic signed [XW-1:0] chk_eta;
   assign chk_band = XW'(ONEI) - XW'(s1_m) - XW'(s1_df);
   assign chk_eta  = XW'(s1_eta);

   p_band_r2: assert property (@(posedge clk) disable iff (!rst_n)
      s1_vld |-> (s1_eta == '0) || (chk_eta < chk_band && -chk_eta < chk_band));

   p_off_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && !$past(bal_en)) |-> (s1_eta == '0));

   p_dwell_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (dwell_a <= $past(s1_per) && dwell_b <= $past(s1_per) &&
                     dwell_c <= $past(s1_per) && dwell_d <= $past(s1_per)));

   p_st_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(s1_df) == '0) |-> (dwell_st == '0));

   p_flag_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && neg_sat) |-> (dwell_a == '0 || dwell_b == '0 ||
                                  dwell_c == '0 || dwell_d == '0));

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, 2));

endmodule

// File: tb/np_balance_adjust_tb.sv
module np_balance_adjust_tb;

   localparam int DW = 16;
   localparam int PW = 16;
   localparam int GF = 12;
   localparam int NVEC = 9;

   typedef struct packed {
      int d1; int d2; int d3; int d4;
      int vhi; int vlo; int gn; int m; int df; int per; int en;
   } vec_t;

   typedef struct packed {
      int eta; int ta; int tb; int tc; int td; int tst; int flag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic bal_en = 1'b0;
   logic signed [DW-1:0] duty_a = '0, duty_b = '0, duty_c = '0, duty_d = '0;
   logic signed [15:0]   vc_hi = '0, vc_lo = '0, gain = '0;
   logic signed [DW-1:0] mod_idx = '0, st_duty = '0;
   logic [PW-1:0]        period = '0;
   logic                 out_valid;
   logic signed [DW-1:0] eta;
   logic [PW-1:0]        dwell_a, dwell_b, dwell_c, dwell_d, dwell_st;
   logic                 neg_sat;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   np_balance_adjust u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bal_en(bal_en),
      .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c), .duty_d(duty_d),
      .vc_hi(vc_hi), .vc_lo(vc_lo), .gain(gain), .mod_idx(mod_idx),
      .st_duty(st_duty), .period(period), .out_valid(out_valid), .eta(eta),
      .dwell_a(dwell_a), .dwell_b(dwell_b), .dwell_c(dwell_c),
      .dwell_d(dwell_d), .dwell_st(dwell_st), .neg_sat(neg_sat)
   );

   // stimulus table: d1 d2 d3 d4 vhi vlo gain m df per en
   function automatic vec_t get_vec(int i);
      case (i)
         0: return '{6000, 8000, 9000, 6000, 1000, 1000, 4096, 26214, 0, 5000, 1};
         1: return '{6000, 8000, 9000, 6000, 1050, 1000, 4096, 26214, 0, 5000, 1};
         2: return '{7000, 8000, 9000, 7000, 900, 1000, 8192, 26214, 3277, 5000, 1};
         3: return '{6000, 8000, 9000, 6000, 3000, 0, 16384, 26214, 3277, 5000, 1};
         4: return '{6000, 8000, 9000, 6000, 3000, 0, 16384, 26214, 3277, 5000, 0};
         5: return '{6000, 8000, 9000, 6000, 3000, 0, 32767, 30000, 3000, 4000, 1};
         6: return '{100, 12000, 12000, 8000, 32767, -32768, 32767, 0, 0, 65535, 1};
         7: return '{9000, 7000, 6000, 9000, -500, 500, -4096, 16384, 1638, 1234, 1};
         default: return '{5000, 11000, 11000, 5000, 999, 1000, 2048, 20000, 500, 3000, 1};
      endcase
   endfunction

   function automatic string get_tag(int i);
      case (i)
         0: return "R1 R5";
         1: return "R11 R4";
         2: return "R4 R7";
         3: return "R2 R8";
         4: return "R3";
         5: return "R2";
         6: return "R1 R8";
         7: return "R1 R6";
         default: return "R1 R6";
      endcase
   endfunction

   function automatic longint dwell_of(longint r, longint per, bit half);
      longint c;
      c = (r < 0) ? 0 : ((r > 32768) ? 32768 : r);
      return half ? ((c * per) >>> 16) : ((c * per) >>> 15);
   endfunction

   function automatic exp_t model(vec_t v);
      exp_t e;
      longint p, lim, et, r1, r4;
      p = (longint'(v.vhi) - longint'(v.vlo)) * longint'(v.gn);
      p = p >>> GF;
      if (p > 32767) p = 32767;
      if (p < -32768) p = -32768;
      lim = 32768 - longint'(v.m) - longint'(v.df) - 1;
      if (v.en == 0 || lim < 0) et = 0;
      else if (p > lim)        et = lim;
      else if (p < -lim)       et = -lim;
      else                     et = p;
      r1 = longint'(v.d1) - v.df - et;
      r4 = longint'(v.d4) - v.df + et;
      e.eta  = int'(et);
      e.ta   = int'(dwell_of(r1, v.per, 1'b0));
      e.tb   = int'(dwell_of(v.d2, v.per, 1'b0));
      e.tc   = int'(dwell_of(v.d3, v.per, 1'b0));
      e.td   = int'(dwell_of(r4, v.per, 1'b0));
      e.tst  = int'(dwell_of(v.df, v.per, 1'b1));
      e.flag = (r1 < 0 || r4 < 0 || v.d2 < 0 || v.d3 < 0) ? 1 : 0;
      return e;
   endfunction

   task automatic check(string tag, string what, longint act, longint expv);
      n_checks++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic drive(vec_t v, bit vld);
      duty_a = DW'(v.d1); duty_b = DW'(v.d2); duty_c = DW'(v.d3); duty_d = DW'(v.d4);
      vc_hi = 16'(v.vhi); vc_lo = 16'(v.vlo); gain = 16'(v.gn);
      mod_idx = DW'(v.m); st_duty = DW'(v.df); period = PW'(v.per);
      bal_en = v.en[0];
      in_valid = vld;
   endtask

   task automatic compare(string tag, exp_t e);
      check(tag, "out_valid", longint'(out_valid), 1);
      check(tag, "eta", longint'(eta), e.eta);
      check(tag, "dwell_a", longint'(dwell_a), e.ta);
      check(tag, "dwell_b", longint'(dwell_b), e.tb);
      check(tag, "dwell_c", longint'(dwell_c), e.tc);
      check(tag, "dwell_d", longint'(dwell_d), e.td);
      check(tag, "dwell_st", longint'(dwell_st), e.tst);
      check(tag, "neg_sat", longint'(neg_sat), e.flag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      exp_t e;
      exp_t e2;
      vec_t v;
      repeat (4) @(negedge clk);
      // R10: reset state
      check("R10", "out_valid", longint'(out_valid), 0);
      check("R10", "eta", longint'(eta), 0);
      check("R10", "dwell_a", longint'(dwell_a), 0);
      check("R10", "dwell_d", longint'(dwell_d), 0);
      check("R10", "dwell_st", longint'(dwell_st), 0);
      check("R10", "neg_sat", longint'(neg_sat), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         v = get_vec(i);
         e = model(v);
         drive(v, 1'b1);
         @(negedge clk);
         in_valid = 1'b0;
         check("R9", "early out_valid", longint'(out_valid), 0);
         @(negedge clk);
         compare(get_tag(i), e);
         @(negedge clk);
         check("R9", "single pulse", longint'(out_valid), 0);
      end

      // hand-worked corners
      v = get_vec(3);
      drive(v, 1'b1);
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      check("R2", "clamped eta", longint'(eta), 3276);
      check("R8", "negative small dwell", longint'(dwell_a), 0);
      check("R8", "flag", longint'(neg_sat), 1);
      v = get_vec(8);
      drive(v, 1'b1);
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      check("R1", "floor of negative", longint'(eta), -1);
      v = get_vec(6);
      drive(v, 1'b1);
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      check("R1", "saturated eta", longint'(eta), 32767);
      check("R8", "high clip dwell", longint'(dwell_d), 65535);
      v = get_vec(1);
      drive(v, 1'b1);
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      check("R11", "no shoot-through", longint'(dwell_st), 0);
      check("R11", "first small", longint'(dwell_a), (5950 * 5000) / 32768);

      // R9: hold while inputs wander without a strobe
      e = model(get_vec(1));
      v = get_vec(6);
      drive(v, 1'b0);
      repeat (3) @(negedge clk);
      check("R9", "hold valid low", longint'(out_valid), 0);
      check("R9", "hold eta", longint'(eta), e.eta);
      check("R9", "hold dwell_a", longint'(dwell_a), e.ta);
      check("R9", "hold dwell_st", longint'(dwell_st), e.tst);

      // R9: back-to-back strobes
      e  = model(get_vec(7));
      e2 = model(get_vec(2));
      drive(get_vec(7), 1'b1);
      @(negedge clk);
      drive(get_vec(2), 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      compare("R9 first", e);
      @(negedge clk);
      compare("R9 second", e2);

      @(negedge clk);
      finish_run();
   end

endmodule